// File: doc/BRIEF.md
# Tick Counter with Compare Interrupt

This block is a free-running cycle counter with a compare register that raises a soft-interrupt request when the count reaches the compare value. Software can write and read both the count and the compare value through plain write-enable/data ports. The top bit of each word is a flag rather than a value bit. On the count it marks the counter as privileged to read. On the compare value it masks the interrupt.

One parameter selects the role of the instance: processor tick, system tick or hypervisor tick. A tick instance routes its one-cycle match pulse to the tick-match soft-interrupt set line. The other two roles route it to the system-tick-match set line. The soft-interrupt register that takes these set pulses sits outside the block.

A compare value of zero never arms the timer. A compare value written at or below the current count is not lost: it fires on the next tick.

Top module: `tick_cmp_timer`

## Requirements
- R1: After reset the count read has bit CNT_W-1 (the privileged-read flag) at 1 and value 0. The compare read is 1 in bit CNT_W-1 (disable) and 0 elsewhere. No match or soft-interrupt pulse is present.
- R2: With no count write, the lower CNT_W-1 bits of the count read advance by exactly one every clock cycle.
- R3: A count write loads bits CNT_W-2..0 into the counter and stores bit CNT_W-1 as the privileged-read flag. Both appear on the count read in the cycle after the write.
- R4: The count read presents the privileged-read flag in bit CNT_W-1: 0 after a write with that bit clear, 1 after a write with it set.
- R5: A compare write stores bits CNT_W-2..0 as the compare value and bit CNT_W-1 as the disable flag. The compare read returns both in the cycle after the write.
- R6: When the count equals an armed compare value during a cycle, match_pulse is high for exactly one cycle, in the following cycle.
- R7: A compare value written while it is at or below the current count still fires. The single pulse appears two cycles after the write cycle.
- R8: A compare value of zero never produces a match pulse, even with the disable flag clear.
- R9: While the disable flag is set, no match pulse is produced.
- R10: A tick-role instance copies match_pulse onto tick_int_set and holds stick_int_set low. System-tick and hypervisor-tick instances copy it onto stick_int_set and hold tick_int_set low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_we | input | 1 | Count write strobe |
| cnt_wdata | input | CNT_W | Count write data; top bit is the privileged-read flag |
| lim_we | input | 1 | Compare write strobe |
| lim_wdata | input | CNT_W | Compare write data; top bit is the interrupt disable |
| cnt_rdata | output | CNT_W | Current count with the privileged-read flag in the top bit |
| lim_rdata | output | CNT_W | Stored compare value with the disable flag in the top bit |
| match_pulse | output | 1 | One-cycle registered match pulse |
| tick_int_set | output | 1 | Set pulse for the tick-match soft-interrupt bit |
| stick_int_set | output | 1 | Set pulse for the system-tick-match soft-interrupt bit |

## Verification
Writes to the count and compare registers show on the read ports one cycle after the write cycle. A match is due one cycle after the cycle in which the count equals the compare value. For a compare value of L written while the count is X, that is L−X cycles after the write lands when L>X. A late value (L≤X) fires one cycle after the write lands. The bench sweeps X and L over offsets on both sides of the count, including zero. It loads the count one cycle before each compare write, so every expected cycle is computed from arithmetic alone. It samples the pulse vector on falling edges over a fixed window and compares it against the computed one-hot (or empty) vector for a tick instance and a hypervisor instance driven together.

// File: rtl/tick_cmp_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the tick/compare timer.
// Assumes: roles are fixed at elaboration time.
package tick_cmp_pkg;
    typedef enum logic [1:0] {
        KIND_TICK = 2'd0,
        KIND_SYS  = 2'd1,
        KIND_HYP  = 2'd2
    } timer_kind_e;
endpackage

// File: rtl/tick_cmp_counter.sv
`timescale 1ns/1ps
// Free-running counter with a privileged-read flag in the top bit.
// Assumes: a load takes priority over the increment in the same cycle;
// the value field wraps silently.
module tick_cmp_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-2:0] cnt_val,
    output logic [CNT_W-1:0] rdata
);
    localparam int VAL_W = CNT_W - 1;

    logic [VAL_W-1:0] cnt_q;
    logic             priv_q;

    // Count register: load on write, otherwise advance by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            priv_q <= 1'b1;
        end else if (load) begin
            cnt_q  <= load_val[VAL_W-1:0];
            priv_q <= load_val[VAL_W];
        end else begin
            cnt_q  <= cnt_q + VAL_W'(1);
        end
    end

    // Read word: flag in the top bit, count below it.
    always_comb begin
        rdata   = {priv_q, cnt_q};
        cnt_val = cnt_q;
    end
endmodule

// File: rtl/tick_cmp_compare.sv
`timescale 1ns/1ps
// Compare register with disable flag, late-write catch-up and a
// registered one-cycle hit output.
// Assumes: cur_cnt is the count of the current cycle (before any load
// that is being written in the same cycle).
module tick_cmp_compare #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CNT_W-1:0] wdata,
    input  logic [CNT_W-2:0] cur_cnt,
    output logic [CNT_W-1:0] rdata,
    output logic             hit_q
);
    localparam int VAL_W = CNT_W - 1;

    logic [VAL_W-1:0] cmp_q;
    logic             dis_q;
    logic             late_q;
    logic             armed;
    logic             hit_d;
    logic             late_d;

    // Armed only with a non-zero value and the disable flag clear.
    always_comb begin
        armed  = (cmp_q != '0) && !dis_q;
        hit_d  = armed && ((cur_cnt == cmp_q) || late_q);
        late_d = (wdata[VAL_W-1:0] != '0) && !wdata[VAL_W] &&
                 (wdata[VAL_W-1:0] <= cur_cnt);
    end

    // Compare value, disable flag and pending late fire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q  <= '0;
            dis_q  <= 1'b1;
            late_q <= 1'b0;
        end else if (we) begin
            cmp_q  <= wdata[VAL_W-1:0];
            dis_q  <= wdata[VAL_W];
            late_q <= late_d;
        end else begin
            late_q <= 1'b0;
        end
    end

    // Registered match pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) hit_q <= 1'b0;
        else        hit_q <= hit_d;
    end

    // Read word: disable in the top bit, compare value below it.
    always_comb rdata = {dis_q, cmp_q};
endmodule

// File: rtl/tick_cmp_route.sv
`timescale 1ns/1ps
// Steers the match pulse to the soft-interrupt set line of the role.
// Assumes: only the tick role uses the tick-match line.
module tick_cmp_route #(
    parameter tick_cmp_pkg::timer_kind_e KIND = tick_cmp_pkg::KIND_TICK
) (
    input  logic hit,
    output logic tick_set,
    output logic stick_set
);
    generate
        if (KIND == tick_cmp_pkg::KIND_TICK) begin : g_tick
            // Tick role drives the tick-match line.
            always_comb begin
                tick_set  = hit;
                stick_set = 1'b0;
            end
        end else begin : g_stick
            // System and hypervisor roles share the system-tick line.
            always_comb begin
                tick_set  = 1'b0;
                stick_set = hit;
            end
        end
    endgenerate
endmodule

// File: rtl/tick_cmp_timer.sv
`timescale 1ns/1ps
// Tick timer top: counter, compare unit and soft-interrupt routing.
// Assumes: single clock domain, CNT_W >= 2.
module tick_cmp_timer #(
    parameter int CNT_W = 64,
    parameter tick_cmp_pkg::timer_kind_e KIND = tick_cmp_pkg::KIND_TICK
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             lim_we,
    input  logic [CNT_W-1:0] lim_wdata,
    output logic [CNT_W-1:0] cnt_rdata,
    output logic [CNT_W-1:0] lim_rdata,
    output logic             match_pulse,
    output logic             tick_int_set,
    output logic             stick_int_set
);
    logic [CNT_W-2:0] cnt_val;

    tick_cmp_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_we),
        .load_val (cnt_wdata),
        .cnt_val  (cnt_val),
        .rdata    (cnt_rdata)
    );

    tick_cmp_compare #(.CNT_W(CNT_W)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (lim_we),
        .wdata   (lim_wdata),
        .cur_cnt (cnt_val),
        .rdata   (lim_rdata),
        .hit_q   (match_pulse)
    );

    tick_cmp_route #(.KIND(KIND)) u_route (
        .hit       (match_pulse),
        .tick_set  (tick_int_set),
        .stick_set (stick_int_set)
    );
endmodule

// File: rtl/tick_cmp_timer_chk.sv
`timescale 1ns/1ps
// Property checker for tick_cmp_timer, attached by bind.
module tick_cmp_timer_chk #(
    parameter int CNT_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_we,
    input logic [CNT_W-1:0] cnt_wdata,
    input logic             lim_we,
    input logic [CNT_W-1:0] lim_wdata,
    input logic [CNT_W-1:0] cnt_rdata,
    input logic [CNT_W-1:0] lim_rdata,
    input logic             match_pulse,
    input logic             tick_int_set,
    input logic             stick_int_set
);
    localparam int VAL_W = CNT_W - 1;

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_we |=> (cnt_rdata[VAL_W-1:0] ==
                     VAL_W'($past(cnt_rdata[VAL_W-1:0]) + VAL_W'(1)))
                    && $stable(cnt_rdata[VAL_W]));

    // R3
    count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> cnt_rdata == $past(cnt_wdata));

    // R5
    limit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lim_we |=> lim_rdata == $past(lim_wdata));

    // R8 R9
    armed_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> $past(!lim_rdata[VAL_W] && (lim_rdata[VAL_W-1:0] != '0)));

    // R10
    route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((tick_int_set || stick_int_set) == match_pulse) &&
        !(tick_int_set && stick_int_set));
endmodule

bind tick_cmp_timer tick_cmp_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cnt_we        (cnt_we),
    .cnt_wdata     (cnt_wdata),
    .lim_we        (lim_we),
    .lim_wdata     (lim_wdata),
    .cnt_rdata     (cnt_rdata),
    .lim_rdata     (lim_rdata),
    .match_pulse   (match_pulse),
    .tick_int_set  (tick_int_set),
    .stick_int_set (stick_int_set)
);

// File: tb/tick_cmp_timer_tb.sv
`timescale 1ns/1ps
module tick_cmp_timer_tb;
    localparam int W  = 16;
    localparam int VW = W - 1;
    localparam int WIN = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cnt_we = 1'b0;
    logic [W-1:0] cnt_wdata = '0;
    logic lim_we = 1'b0;
    logic [W-1:0] lim_wdata = '0;

    logic [W-1:0] t_cnt, t_lim, h_cnt, h_lim;
    logic t_match, t_tick, t_stick, h_match, h_tick, h_stick;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    tick_cmp_timer #(.CNT_W(W), .KIND(tick_cmp_pkg::KIND_TICK)) u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .lim_we(lim_we), .lim_wdata(lim_wdata), .cnt_rdata(t_cnt),
        .lim_rdata(t_lim), .match_pulse(t_match), .tick_int_set(t_tick),
        .stick_int_set(t_stick));

    tick_cmp_timer #(.CNT_W(W), .KIND(tick_cmp_pkg::KIND_HYP)) u_dut_hyp (
        .clk(clk), .rst_n(rst_n), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .lim_we(lim_we), .lim_wdata(lim_wdata), .cnt_rdata(h_cnt),
        .lim_rdata(h_lim), .match_pulse(h_match), .tick_int_set(h_tick),
        .stick_int_set(h_stick));

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Load count X (flag set), then write compare {dis, L}; watch WIN cycles.
    task automatic trial(input int x, input int l, input bit dis, input string req);
        logic [WIN-1:0] tm, tt, ts, hm, ht, hs, exp;
        int idx;
        tm = '0; tt = '0; ts = '0; hm = '0; ht = '0; hs = '0; exp = '0;
        // quiesce with disabled compare
        @(negedge clk);
        lim_we = 1'b1; lim_wdata = {1'b1, {VW{1'b0}}};
        @(negedge clk);
        lim_we = 1'b0;
        @(negedge clk);
        cnt_we = 1'b1; cnt_wdata = {1'b1, VW'(x)};
        @(negedge clk);
        cnt_we = 1'b0;
        lim_we = 1'b1; lim_wdata = {dis, VW'(l)};
        for (int i = 0; i < WIN; i++) begin
            @(negedge clk);
            lim_we = 1'b0;
            tm[i] = t_match; tt[i] = t_tick; ts[i] = t_stick;
            hm[i] = h_match; ht[i] = h_tick; hs[i] = h_stick;
        end
        if (l != 0 && !dis) begin
            idx = (l > x) ? (l - x) : 1;
            if (idx < WIN) exp[idx] = 1'b1;
        end
        check(tm == exp, req, 32'(tm), 32'(exp));
        check(tt == exp && ts == '0, "R10 tick role", {5'd0, tt, 5'd0, ts}, {5'd0, exp, 16'd0});
        check(hs == exp && ht == '0, "R10 hyp role", {5'd0, hs, 5'd0, ht}, {5'd0, exp, 16'd0});
    endtask

    initial begin : wdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin : main
        logic [W-1:0] a;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: values right after release, before the next edge
        check(t_cnt == {1'b1, {VW{1'b0}}}, "R1 count", 32'(t_cnt), 32'h8000);
        check(t_lim == {1'b1, {VW{1'b0}}}, "R1 compare", 32'(t_lim), 32'h8000);
        check(!t_match && !t_tick && !h_stick, "R1 pulses", {t_match, t_tick, h_stick}, 0);
        // R2: five cycles advance by five
        a = t_cnt;
        repeat (5) @(negedge clk);
        check(t_cnt == a + 16'd5, "R2 increment", 32'(t_cnt), 32'(a + 16'd5));
        // R3 R4: load with flag clear
        cnt_we = 1'b1; cnt_wdata = 16'h1234;
        @(negedge clk);
        cnt_we = 1'b0;
        check(t_cnt == 16'h1234, "R3 load value", 32'(t_cnt), 32'h1234);
        check(t_cnt[VW] == 1'b0, "R4 flag clear", 32'(t_cnt[VW]), 0);
        cnt_we = 1'b1; cnt_wdata = 16'h8042;
        @(negedge clk);
        cnt_we = 1'b0;
        check(t_cnt == 16'h8042, "R4 flag set", 32'(t_cnt), 32'h8042);
        repeat (3) @(negedge clk);
        check(t_cnt == 16'h8045, "R3 run after load", 32'(t_cnt), 32'h8045);
        // R5: compare read-back
        lim_we = 1'b1; lim_wdata = 16'hA5A5;
        @(negedge clk);
        lim_we = 1'b0;
        check(t_lim == 16'hA5A5, "R5 compare readback", 32'(t_lim), 32'hA5A5);
        lim_we = 1'b1; lim_wdata = 16'h0777;
        @(negedge clk);
        lim_we = 1'b0;
        check(t_lim == 16'h0777, "R5 disable clear readback", 32'(t_lim), 32'h0777);
        // Sweep compare offsets around several count origins
        foreach (a[k]) begin end
        for (int b = 0; b < 3; b++) begin
            int x;
            x = (b == 0) ? 5 : (b == 1) ? 'h100 : 'h7FF0;
            for (int d = -5; d <= 6; d++) begin
                int l;
                l = x + d;
                if (l == 0)      trial(x, l, 1'b0, "R8 zero compare");
                else if (d <= 0) trial(x, l, 1'b0, "R7 late compare");
                else             trial(x, l, 1'b0, "R6 equal match");
            end
            // R9: disabled compare ahead and behind the count
            trial(x, x + 2, 1'b1, "R9 disabled ahead");
            trial(x, x - 1, 1'b1, "R9 disabled late");
        end
        // R8: zero compare with a large count
        trial('h7000, 0, 1'b0, "R8 zero compare high count");
        summary();
        $finish;
    end
endmodule